// File: doc/BRIEF.md
# DMA Channel Interrupt Aggregator

This block collects the interrupt causes of a twelve-channel DMA engine. There are ten peripheral channels, which move data between memory and a peripheral in either direction, and two memory-to-memory channels. Each channel has three causes: transfer complete, channel stalled, and next buffer free. The engine marks a cause by pulsing one input for one cycle. The block latches that pulse into a sticky status bit. Each channel also holds a three-bit enable mask. The causes that are both pending and enabled are ORed into one registered interrupt line per channel, and the twelve lines leave the block as a bus.

Software works with the block through a simple word-addressed register port. Each channel has an enable register and a status register, and status bits are cleared by writing 1 to them. One read-only global register returns the current state of the interrupt bus. Reads are registered: the data appears on the cycle after the read strobe.

Top module: `dma_irq_aggregator`

## Requirements
- R1: After reset, every status bit, every enable bit, the whole `irq_o` bus and `reg_rdata` are zero.
- R2: A one-cycle pulse on `ev_done[c]`, `ev_stall[c]` or `ev_nfb[c]` sets bit 0, bit 1 or bit 2 of channel c's status register. The status register of channel c is at word address 2c+1. A status bit never sets without its event.
- R3: A set status bit stays set until a write to that status register with 1 in that bit position. A write with 0 in a bit position leaves that bit unchanged.
- R4: When an event pulse and a write-1-to-clear reach the same status bit on the same clock edge, the bit ends up set.
- R5: After every clock edge, `irq_o[c]` equals the OR over the three sources of (status AND enable) as held for channel c after that edge.
- R6: A source whose enable bit is 0 still records its status bit but does not drive the channel's line.
- R7: Writing the enable register of channel c (word address 2c, bits [2:0] in the same order as the status bits) makes a source that is already pending assert `irq_o[c]` from that write edge onward.
- R8: Word address 24 returns `irq_o` in bits [11:0]. Writes to that address change nothing.
- R9: An event or a register write on one channel does not change the status, the enable bits or the line of any other channel.
- R10: When `reg_re` is high on a clock edge, `reg_rdata` takes the value of the addressed register at that edge and then holds it while `reg_re` is low. An unmapped address (25 to 31) reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_done | input | 12 | Per-channel transfer-complete event pulses |
| ev_stall | input | 12 | Per-channel stall event pulses |
| ev_nfb | input | 12 | Per-channel next-buffer-free event pulses |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 5 | Word address |
| reg_wdata | input | 3 | Write data (enable mask or clear mask) |
| reg_rdata | output | 12 | Registered read data |
| irq_o | output | 12 | Registered per-channel interrupt lines |

## Verification
The checker assumes that event inputs are single-cycle pulses driven with the clock. It also assumes that the register strobes are never left unknown after reset, because the sticky and clear properties count a write as a clear only when the decoded write reaches that channel. The bench keeps to this by changing every input on the falling edge and dropping each pulse or strobe after exactly one cycle. It also drives the simultaneous set-and-clear case on purpose, so that the priority rule is exercised rather than assumed.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int SRC_N    = 3;
  localparam int SRC_DONE = 0;
  localparam int SRC_STALL = 1;
  localparam int SRC_NFB  = 2;
  typedef logic [SRC_N-1:0] src_vec_t;
endpackage

// File: rtl/dma_irq_chan.sv
module dma_irq_chan
  import dma_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  src_vec_t set_i,
  input  logic     en_we_i,
  input  logic     stat_we_i,
  input  src_vec_t wdata_i,
  output src_vec_t stat_o,
  output src_vec_t en_o,
  output logic     line_o
);
  src_vec_t stat_q, stat_d;
  src_vec_t en_q, en_d;
  src_vec_t clr_mask;
  logic     line_q, line_d;
  logic     stat_upd, en_upd;

  always_comb begin
    clr_mask = stat_we_i ? wdata_i : '0;
    // set has priority over clear
    stat_d   = (stat_q & ~clr_mask) | set_i;
    en_d     = en_we_i ? wdata_i : en_q;
    line_d   = |(stat_d & en_d);
    stat_upd = stat_we_i | (|set_i);
    en_upd   = en_we_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
      line_q <= 1'b0;
    end else begin
      if (stat_upd) stat_q <= stat_d;
      if (en_upd)   en_q   <= en_d;
      line_q <= line_d;
    end
  end

  assign stat_o = stat_q;
  assign en_o   = en_q;
  assign line_o = line_q;
endmodule

// File: rtl/dma_irq_regif.sv
module dma_irq_regif
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 12,
  localparam int ADDR_W = $clog2(2*NUM_CH+1),
  localparam int RD_W   = NUM_CH
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reg_we,
  input  logic                        reg_re,
  input  logic [ADDR_W-1:0]           reg_addr,
  input  logic [NUM_CH-1:0][SRC_N-1:0] stat_i,
  input  logic [NUM_CH-1:0][SRC_N-1:0] en_i,
  input  logic [NUM_CH-1:0]           irq_i,
  output logic [NUM_CH-1:0]           en_we_o,
  output logic [NUM_CH-1:0]           stat_we_o,
  output logic [RD_W-1:0]             rdata_o
);
  localparam logic [ADDR_W-1:0] GLOBAL_ADDR = ADDR_W'(2*NUM_CH);

  logic [RD_W-1:0] rd_d, rd_q;

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      en_we_o[c]   = reg_we && (reg_addr == ADDR_W'(2*c));
      stat_we_o[c] = reg_we && (reg_addr == ADDR_W'(2*c+1));
    end
  end

  always_comb begin
    rd_d = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (reg_addr == ADDR_W'(2*c))   rd_d = RD_W'(en_i[c]);
      if (reg_addr == ADDR_W'(2*c+1)) rd_d = RD_W'(stat_i[c]);
    end
    if (reg_addr == GLOBAL_ADDR) rd_d = irq_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else if (reg_re) rd_q <= rd_d;
  end

  assign rdata_o = rd_q;
endmodule

// File: rtl/dma_irq_aggregator.sv
module dma_irq_aggregator
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 12,
  localparam int ADDR_W = $clog2(2*NUM_CH+1),
  localparam int FLAT_W = NUM_CH*SRC_N
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] ev_done,
  input  logic [NUM_CH-1:0] ev_stall,
  input  logic [NUM_CH-1:0] ev_nfb,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [SRC_N-1:0]  reg_wdata,
  output logic [NUM_CH-1:0] reg_rdata,
  output logic [NUM_CH-1:0] irq_o
);
  logic [NUM_CH-1:0][SRC_N-1:0] stat_all, en_all;
  logic [NUM_CH-1:0]            en_we, stat_we, line;
  logic [FLAT_W-1:0]            ev_flat, clr_flat, stat_flat, en_flat;

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      src_vec_t set_v;
      always_comb begin
        set_v            = '0;
        set_v[SRC_DONE]  = ev_done[c];
        set_v[SRC_STALL] = ev_stall[c];
        set_v[SRC_NFB]   = ev_nfb[c];
      end

      dma_irq_chan u_chan (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (set_v),
        .en_we_i  (en_we[c]),
        .stat_we_i(stat_we[c]),
        .wdata_i  (reg_wdata),
        .stat_o   (stat_all[c]),
        .en_o     (en_all[c]),
        .line_o   (line[c])
      );

      assign ev_flat[c*SRC_N +: SRC_N]   = set_v;
      assign clr_flat[c*SRC_N +: SRC_N]  = stat_we[c] ? reg_wdata : '0;
      assign stat_flat[c*SRC_N +: SRC_N] = stat_all[c];
      assign en_flat[c*SRC_N +: SRC_N]   = en_all[c];
    end
  endgenerate

  dma_irq_regif #(.NUM_CH(NUM_CH)) u_regif (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .reg_re   (reg_re),
    .reg_addr (reg_addr),
    .stat_i   (stat_all),
    .en_i     (en_all),
    .irq_i    (line),
    .en_we_o  (en_we),
    .stat_we_o(stat_we),
    .rdata_o  (reg_rdata)
  );

  assign irq_o = line;
endmodule

// File: rtl/dma_irq_chk.sv
module dma_irq_chk #(
  parameter int NUM_CH = 12,
  parameter int SRC_N  = 3,
  localparam int FLAT_W = NUM_CH*SRC_N
) (
  input logic              clk,
  input logic              rst_n,
  input logic [FLAT_W-1:0] ev_flat,
  input logic [FLAT_W-1:0] clr_flat,
  input logic [FLAT_W-1:0] stat_flat,
  input logic [FLAT_W-1:0] en_flat,
  input logic [NUM_CH-1:0] irq_o,
  input logic              reg_re,
  input logic [NUM_CH-1:0] reg_rdata
);
  generate
    for (genvar i = 0; i < FLAT_W; i++) begin : g_bit
      p_event_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_flat[i] |=> stat_flat[i]);
      p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_flat[i] && !ev_flat[i]) |=> !stat_flat[i]);
      p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_flat[i] && !clr_flat[i]) |=> stat_flat[i]);
      p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_flat[i] && !ev_flat[i]) |=> !stat_flat[i]);
    end
    for (genvar c = 0; c < NUM_CH; c++) begin : g_line
      p_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o[c] == (|(stat_flat[c*SRC_N +: SRC_N] & en_flat[c*SRC_N +: SRC_N])));
    end
  endgenerate

  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_re |=> $stable(reg_rdata));
endmodule

bind dma_irq_aggregator dma_irq_chk #(.NUM_CH(NUM_CH), .SRC_N(dma_irq_pkg::SRC_N)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ev_flat  (ev_flat),
  .clr_flat (clr_flat),
  .stat_flat(stat_flat),
  .en_flat  (en_flat),
  .irq_o    (irq_o),
  .reg_re   (reg_re),
  .reg_rdata(reg_rdata)
);

// File: tb/sim_dma_irq_aggregator.sv
module sim_dma_irq_aggregator;
  localparam int NCH = 12;
  localparam int GLOBAL_ADDR = 24;

  logic clk, rst_n;
  logic [NCH-1:0] ev_done, ev_stall, ev_nfb;
  logic reg_we, reg_re;
  logic [4:0] reg_addr;
  logic [2:0] reg_wdata;
  logic [NCH-1:0] reg_rdata, irq_o;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;
  int    exp_q[$];
  string req_q[$];

  dma_irq_aggregator #(.NUM_CH(NCH)) u0 (
    .clk(clk), .rst_n(rst_n), .ev_done(ev_done), .ev_stall(ev_stall), .ev_nfb(ev_nfb),
    .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_we = 1; reg_addr = 5'(a); reg_wdata = 3'(d);
    @(negedge clk);
    reg_we = 0;
  endtask

  // driver: issue read and push expected result into the scoreboard
  task automatic rd(input int a, input int exp, input string req);
    @(negedge clk);
    reg_re = 1; reg_addr = 5'(a);
    exp_q.push_back(exp);
    req_q.push_back(req);
    @(negedge clk);
    reg_re = 0;
  endtask

  task automatic pulse(input int kind, input int ch);
    @(negedge clk);
    case (kind)
      0: ev_done[ch] = 1;
      1: ev_stall[ch] = 1;
      default: ev_nfb[ch] = 1;
    endcase
    @(negedge clk);
    ev_done = '0; ev_stall = '0; ev_nfb = '0;
  endtask

  // monitor: pop expected values as read data appears
  initial begin
    forever begin
      @(posedge clk);
      if (rst_n && reg_re) begin
        @(negedge clk);
        if (exp_q.size() == 0) chk("scoreboard", 1, 0);
        else chk(req_q.pop_front(), int'(reg_rdata), exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0; ev_done = '0; ev_stall = '0; ev_nfb = '0;
    reg_we = 0; reg_re = 0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    chk("R1 irq", int'(irq_o), 0);
    chk("R1 rdata", int'(reg_rdata), 0);
    rst_n = 1;
    rd(1, 0, "R1 status ch0");
    rd(10, 0, "R1 enable ch5");
    rd(GLOBAL_ADDR, 0, "R1 global");

    // status recorded while disabled
    pulse(0, 3);
    chk("R6 line stays low", int'(irq_o), 0);
    rd(7, 1, "R2 done ch3");
    pulse(1, 3);
    rd(7, 3, "R2 stall ch3");
    pulse(2, 11);
    rd(23, 4, "R2 nfb ch11");
    rd(9, 0, "R9 ch4 untouched");
    chk("R6 no line", int'(irq_o), 0);

    // late enable
    wr(6, 3'b010);
    chk("R7 late enable", int'(irq_o), 12'h008);
    rd(GLOBAL_ADDR, 12'h008, "R8 global mirror");
    rd(6, 2, "R7 enable readback");

    // write-1-to-clear
    wr(7, 3'b010);
    chk("R5 line drops", int'(irq_o), 0);
    rd(7, 1, "R3 clear stall");
    wr(7, 3'b000);
    rd(7, 1, "R3 zero write keeps");

    // set wins over clear
    @(negedge clk);
    ev_done[3] = 1; reg_we = 1; reg_addr = 5'd7; reg_wdata = 3'b001;
    @(negedge clk);
    ev_done = '0; reg_we = 0;
    rd(7, 1, "R4 set wins");
    wr(7, 3'b001);
    rd(7, 0, "R3 cleared");

    // global read-only
    wr(22, 3'b100);
    chk("R5 ch11 line", int'(irq_o), 12'h800);
    wr(GLOBAL_ADDR, 3'b111);
    rd(GLOBAL_ADDR, 12'h800, "R8 write ignored");
    chk("R8 bus unchanged", int'(irq_o), 12'h800);

    // enabled event
    wr(0, 3'b111);
    chk("R5 enabled no pend", int'(irq_o), 12'h800);
    pulse(1, 0);
    chk("R5 enabled event", int'(irq_o), 12'h801);
    rd(1, 2, "R2 stall ch0");
    rd(3, 0, "R9 ch1 untouched");
    rd(2, 0, "R9 ch1 enable");

    // unmapped and hold
    rd(30, 0, "R10 unmapped");
    rd(23, 4, "R10 ch11 status");
    @(negedge clk);
    reg_addr = 5'd1;
    pulse(0, 5);
    repeat (2) @(negedge clk);
    chk("R10 hold", int'(reg_rdata), 4);

    repeat (3) @(negedge clk);
    chk("scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule